// File: doc/BRIEF.md
# Raster Timing and Test Pattern Generator

This block produces a complete video raster from a set of programmable timing values. A horizontal counter and a vertical counter step through each line and frame. Windows on these counters give the horizontal sync, the vertical sync and the data-enable strobe. The sync polarities are programmable. When interlacing is switched on, frames alternate between two fields. The second field has its own vertical active window and its own vertical sync window, and its vertical sync starts and stops at a programmable pixel position within the line.

While data-enable is high, the block paints a synthetic pattern on three 8-bit components. A separate mode is chosen for each axis: gradient, inversion or line. Either axis can advance its pattern index only on every second pixel or line. Any component can be overridden to a fixed level. Outside the active window, the luma component carries one programmable blank level and the two chroma components carry another. The block is used as a stand-alone raster source in front of a video transmitter, for bring-up and for display testing.

Top module: `raster_pattern_gen`

## Requirements
- R1: While `rst_n` is low, `de`, `hsync`, `vsync` and all of `pix` are 0.
- R2: With `en` low at a rising edge, after that edge `de` is 0, `hsync` equals `!hs_pol`, `vsync` equals `!vs_pol`, and `pix` holds the blank levels. The raster counters return to line 0, pixel 0, field 0, so the first enabled edge afterwards presents that position.
- R3: The pixel counter runs from 0 to `h_total`-1 and the line counter then advances. The line counter wraps after `v_total`-1. The outputs are registered, so the outputs seen after an edge describe the position the counters held at that edge. Hsync therefore repeats every `h_total` cycles.
- R4: In field 0, `de` is 1 exactly when the pixel count is in [`h_de_start`, `h_de_end`) and the line count is in [`v_de_start`, `v_de_end`).
- R5: `hsync` equals `hs_pol` when the pixel count is in [`h_sync_start`, `h_sync_end`), and `!hs_pol` otherwise.
- R6: In field 0, `vsync` equals `vs_pol` for all lines in [`v_sync_start`, `v_sync_end`), starting at pixel 0, and `!vs_pol` otherwise.
- R7: With `interlace_en` high, the field flips at each frame wrap; with it low, the field returns to 0 at the wrap. In field 1, the line window for `de` is [`f2_de_start`, `f2_de_end`). In field 1, `vsync` is active from position (line `f2_sync_start`, pixel `f2_sync_hpos`) up to, but not including, position (line `f2_sync_end`, pixel `f2_sync_hpos`).
- R8: Let x be the pixel count minus `h_de_start`, and let y be the line count minus the active field's line-window start. Each component k (pixel bits [8k+7:8k]) starts from `init_color[8k+7:8k]` and adds x·`h_step` when `h_mode`=00 and y·`v_step` when `v_mode`=00. The sum is taken modulo 256.
- R9: Mode 01 (inversion) complements the sum when the index on that axis is odd. When both axes are in mode 01, the two complements cancel.
- R10: Mode 1x (line) forces the component to 0 unless the index on that axis is a multiple of 8. This is applied after the inversion.
- R11: With `h_rep2` set, the horizontal index is x/2 (rounded down). With `v_rep2` set, the vertical index is y/2.
- R12: The 2-bit field `ch_sel[2k+1:2k]` selects what component k shows while `de` is high: 00 gives the pattern value, 01 gives 0x00, 10 gives 0x80 and 11 gives 0xFF.
- R13: While `de` is low, `pix[15:8]` (luma) equals `blank_luma`, and `pix[23:16]` and `pix[7:0]` equal `blank_chroma`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run the raster; low holds it at the origin, idle |
| h_total | input | 13 | Pixels per line |
| h_de_start | input | 13 | First active pixel |
| h_de_end | input | 13 | First pixel after the active span |
| h_sync_start | input | 13 | First hsync pixel |
| h_sync_end | input | 13 | First pixel after hsync |
| v_total | input | 12 | Lines per frame |
| v_de_start | input | 12 | First active line, field 0 |
| v_de_end | input | 12 | First line after the active span, field 0 |
| v_sync_start | input | 12 | First vsync line, field 0 |
| v_sync_end | input | 12 | First line after vsync, field 0 |
| interlace_en | input | 1 | Alternate fields each frame |
| f2_de_start | input | 12 | First active line, field 1 |
| f2_de_end | input | 12 | First line after the active span, field 1 |
| f2_sync_start | input | 12 | Vsync start line, field 1 |
| f2_sync_end | input | 12 | Vsync end line, field 1 |
| f2_sync_hpos | input | 13 | Pixel at which field-1 vsync toggles |
| hs_pol | input | 1 | Hsync active level |
| vs_pol | input | 1 | Vsync active level |
| h_mode | input | 2 | Horizontal pattern mode |
| v_mode | input | 2 | Vertical pattern mode |
| h_rep2 | input | 1 | Horizontal index advances every second pixel |
| v_rep2 | input | 1 | Vertical index advances every second line |
| h_step | input | 8 | Gradient increment per pixel |
| v_step | input | 8 | Gradient increment per line |
| init_color | input | 24 | Start values, component k at bits [8k+7:8k] |
| ch_sel | input | 6 | Per-component override selects |
| blank_luma | input | 8 | Luma level outside the active window |
| blank_chroma | input | 8 | Chroma level outside the active window |
| pix | output | 24 | Pixel data, luma at bits [15:8] |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |

## Verification
The bench goes after the half-open window edges. A design that compares with `<=` would stretch `de`, `hsync` or `vsync` by one pixel or one line. It also targets the field-1 vsync, which must toggle in the middle of a line; a design that used whole lines would move that edge by up to a full line. Both axes in inversion mode are run together, as is line mode combined with the every-second step, because an error in the order of complement, zeroing and halving produces values that differ only on odd or non-multiple-of-8 positions. Disabling the block mid-frame must restart the raster at the origin; a design that merely froze the counters would resume at a shifted position, and every later sync edge would land out of place.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

   typedef enum logic [1:0] {
      PAT_GRAD  = 2'b00,
      PAT_INV   = 2'b01,
      PAT_LINE  = 2'b10,
      PAT_LINE2 = 2'b11
   } pat_mode_e;

   typedef enum logic [1:0] {
      SEL_GEN  = 2'b00,
      SEL_ZERO = 2'b01,
      SEL_MID  = 2'b10,
      SEL_FULL = 2'b11
   } chan_sel_e;

   localparam int POS_W = 16;

   // true when raster position (line, pixel) is at or beyond (ref_line, ref_pix)
   function automatic logic pos_ge(input logic [POS_W-1:0] line,
                                   input logic [POS_W-1:0] pixel,
                                   input logic [POS_W-1:0] ref_line,
                                   input logic [POS_W-1:0] ref_pix);
      return (line > ref_line) || ((line == ref_line) && (pixel >= ref_pix));
   endfunction

endpackage

// File: rtl/rpg_raster_cnt.sv
module rpg_raster_cnt #(
   parameter int H_BITS = 13,
   parameter int V_BITS = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              interlace_en,
   input  logic [H_BITS-1:0] h_total,
   input  logic [V_BITS-1:0] v_total,
   output logic [H_BITS-1:0] h_cnt,
   output logic [V_BITS-1:0] v_cnt,
   output logic              field
);

   localparam int HN_W = H_BITS + 1;
   localparam int VN_W = V_BITS + 1;

   logic [HN_W-1:0] h_nxt;
   logic [VN_W-1:0] v_nxt;
   logic            h_wrap;
   logic            v_wrap;

   assign h_nxt  = {1'b0, h_cnt} + HN_W'(1);
   assign v_nxt  = {1'b0, v_cnt} + VN_W'(1);
   assign h_wrap = h_nxt >= {1'b0, h_total};
   assign v_wrap = v_nxt >= {1'b0, v_total};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_cnt <= '0;
         v_cnt <= '0;
         field <= 1'b0;
      end else if (!en) begin
         h_cnt <= '0;
         v_cnt <= '0;
         field <= 1'b0;
      end else if (h_wrap) begin
         h_cnt <= '0;
         if (v_wrap) begin
            v_cnt <= '0;
            field <= interlace_en & ~field;
         end else begin
            v_cnt <= v_nxt[V_BITS-1:0];
         end
      end else begin
         h_cnt <= h_nxt[H_BITS-1:0];
      end
   end

endmodule

// File: rtl/rpg_timing_decode.sv
module rpg_timing_decode
   import rpg_pkg::*;
#(
   parameter int H_BITS = 13,
   parameter int V_BITS = 12,
   parameter int IDX_W  = 9
) (
   input  logic              field,
   input  logic [H_BITS-1:0] h_cnt,
   input  logic [V_BITS-1:0] v_cnt,
   input  logic [H_BITS-1:0] h_de_start,
   input  logic [H_BITS-1:0] h_de_end,
   input  logic [H_BITS-1:0] h_sync_start,
   input  logic [H_BITS-1:0] h_sync_end,
   input  logic [V_BITS-1:0] v_de_start,
   input  logic [V_BITS-1:0] v_de_end,
   input  logic [V_BITS-1:0] v_sync_start,
   input  logic [V_BITS-1:0] v_sync_end,
   input  logic [V_BITS-1:0] f2_de_start,
   input  logic [V_BITS-1:0] f2_de_end,
   input  logic [V_BITS-1:0] f2_sync_start,
   input  logic [V_BITS-1:0] f2_sync_end,
   input  logic [H_BITS-1:0] f2_sync_hpos,
   output logic              de_act,
   output logic              hs_act,
   output logic              vs_act,
   output logic [IDX_W-1:0]  x_idx,
   output logic [IDX_W-1:0]  y_idx
);

   logic [V_BITS-1:0] win_top;
   logic [V_BITS-1:0] win_bot;
   logic [V_BITS-1:0] vs_first;
   logic [V_BITS-1:0] vs_last;
   logic [H_BITS-1:0] vs_pix;
   logic              h_in;
   logic              v_in;
   logic              vs_past_start;
   logic              vs_past_end;

   // field-dependent vertical parameters
   assign win_top  = field ? f2_de_start   : v_de_start;
   assign win_bot  = field ? f2_de_end     : v_de_end;
   assign vs_first = field ? f2_sync_start : v_sync_start;
   assign vs_last  = field ? f2_sync_end   : v_sync_end;
   assign vs_pix   = field ? f2_sync_hpos  : '0;

   assign h_in   = (h_cnt >= h_de_start) && (h_cnt < h_de_end);
   assign v_in   = (v_cnt >= win_top) && (v_cnt < win_bot);
   assign de_act = h_in && v_in;
   assign hs_act = (h_cnt >= h_sync_start) && (h_cnt < h_sync_end);

   assign vs_past_start = pos_ge(POS_W'(v_cnt), POS_W'(h_cnt), POS_W'(vs_first), POS_W'(vs_pix));
   assign vs_past_end   = pos_ge(POS_W'(v_cnt), POS_W'(h_cnt), POS_W'(vs_last), POS_W'(vs_pix));
   assign vs_act        = vs_past_start && !vs_past_end;

   // only the low bits of the offsets reach the pattern arithmetic
   assign x_idx = IDX_W'(h_cnt - h_de_start);
   assign y_idx = IDX_W'(v_cnt - win_top);

endmodule

// File: rtl/rpg_pattern_core.sv
module rpg_pattern_core
   import rpg_pkg::*;
#(
   parameter int CH_BITS   = 8,
   parameter int LINE_LOG2 = 3,
   parameter int IDX_W     = CH_BITS + 1
) (
   input  logic [IDX_W-1:0]   x_idx,
   input  logic [IDX_W-1:0]   y_idx,
   input  logic [1:0]         h_mode,
   input  logic [1:0]         v_mode,
   input  logic               h_rep2,
   input  logic               v_rep2,
   input  logic [CH_BITS-1:0] h_step,
   input  logic [CH_BITS-1:0] v_step,
   output logic [CH_BITS-1:0] offset,
   output logic               invert,
   output logic               kill
);

   logic [CH_BITS-1:0] xs;
   logic [CH_BITS-1:0] ys;
   logic [CH_BITS-1:0] h_term;
   logic [CH_BITS-1:0] v_term;
   pat_mode_e          hm;
   pat_mode_e          vm;

   assign hm = pat_mode_e'(h_mode);
   assign vm = pat_mode_e'(v_mode);

   assign xs = h_rep2 ? x_idx[IDX_W-1:1] : x_idx[CH_BITS-1:0];
   assign ys = v_rep2 ? y_idx[IDX_W-1:1] : y_idx[CH_BITS-1:0];

   assign h_term = (hm == PAT_GRAD) ? CH_BITS'(xs * h_step) : '0;
   assign v_term = (vm == PAT_GRAD) ? CH_BITS'(ys * v_step) : '0;
   assign offset = h_term + v_term;

   assign invert = ((hm == PAT_INV) && xs[0]) ^ ((vm == PAT_INV) && ys[0]);

   assign kill = (h_mode[1] && (xs[LINE_LOG2-1:0] != '0)) ||
                 (v_mode[1] && (ys[LINE_LOG2-1:0] != '0));

endmodule

// File: rtl/raster_pattern_gen.sv
module raster_pattern_gen
   import rpg_pkg::*;
#(
   parameter int H_BITS    = 13,
   parameter int V_BITS    = 12,
   parameter int CH_BITS   = 8,
   parameter int NUM_CH    = 3,
   parameter int LUMA_CH   = 1,
   parameter int LINE_LOG2 = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   input  logic [H_BITS-1:0]         h_total,
   input  logic [H_BITS-1:0]         h_de_start,
   input  logic [H_BITS-1:0]         h_de_end,
   input  logic [H_BITS-1:0]         h_sync_start,
   input  logic [H_BITS-1:0]         h_sync_end,
   input  logic [V_BITS-1:0]         v_total,
   input  logic [V_BITS-1:0]         v_de_start,
   input  logic [V_BITS-1:0]         v_de_end,
   input  logic [V_BITS-1:0]         v_sync_start,
   input  logic [V_BITS-1:0]         v_sync_end,
   input  logic                      interlace_en,
   input  logic [V_BITS-1:0]         f2_de_start,
   input  logic [V_BITS-1:0]         f2_de_end,
   input  logic [V_BITS-1:0]         f2_sync_start,
   input  logic [V_BITS-1:0]         f2_sync_end,
   input  logic [H_BITS-1:0]         f2_sync_hpos,
   input  logic                      hs_pol,
   input  logic                      vs_pol,
   input  logic [1:0]                h_mode,
   input  logic [1:0]                v_mode,
   input  logic                      h_rep2,
   input  logic                      v_rep2,
   input  logic [CH_BITS-1:0]        h_step,
   input  logic [CH_BITS-1:0]        v_step,
   input  logic [NUM_CH*CH_BITS-1:0] init_color,
   input  logic [NUM_CH*2-1:0]       ch_sel,
   input  logic [CH_BITS-1:0]        blank_luma,
   input  logic [CH_BITS-1:0]        blank_chroma,
   output logic [NUM_CH*CH_BITS-1:0] pix,
   output logic                      hsync,
   output logic                      vsync,
   output logic                      de
);

   localparam int IDX_W  = CH_BITS + 1;
   localparam int PIX_W  = NUM_CH * CH_BITS;
   localparam logic [CH_BITS-1:0] LVL_MID  = CH_BITS'(1) << (CH_BITS - 1);
   localparam logic [CH_BITS-1:0] LVL_FULL = '1;

   // elaboration-time parameter checks
   if (H_BITS < IDX_W || H_BITS > POS_W) begin : g_bad_h
      $error("H_BITS must lie between CH_BITS+1 and %0d", POS_W);
   end
   if (V_BITS < IDX_W || V_BITS > POS_W) begin : g_bad_v
      $error("V_BITS must lie between CH_BITS+1 and %0d", POS_W);
   end
   if (LUMA_CH < 0 || LUMA_CH >= NUM_CH) begin : g_bad_luma
      $error("LUMA_CH must name one of the NUM_CH components");
   end
   if (LINE_LOG2 < 1 || LINE_LOG2 > CH_BITS) begin : g_bad_line
      $error("LINE_LOG2 must lie between 1 and CH_BITS");
   end

   logic [H_BITS-1:0]  h_cnt;
   logic [V_BITS-1:0]  v_cnt;
   logic               field;
   logic               de_act;
   logic               hs_act;
   logic               vs_act;
   logic               de_live;
   logic [IDX_W-1:0]   x_idx;
   logic [IDX_W-1:0]   y_idx;
   logic [CH_BITS-1:0] offset;
   logic               invert;
   logic               kill;
   logic [PIX_W-1:0]   pix_nxt;

   rpg_raster_cnt #(
      .H_BITS (H_BITS),
      .V_BITS (V_BITS)
   ) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (en),
      .interlace_en (interlace_en),
      .h_total      (h_total),
      .v_total      (v_total),
      .h_cnt        (h_cnt),
      .v_cnt        (v_cnt),
      .field        (field)
   );

   rpg_timing_decode #(
      .H_BITS (H_BITS),
      .V_BITS (V_BITS),
      .IDX_W  (IDX_W)
   ) u_dec (
      .field         (field),
      .h_cnt         (h_cnt),
      .v_cnt         (v_cnt),
      .h_de_start    (h_de_start),
      .h_de_end      (h_de_end),
      .h_sync_start  (h_sync_start),
      .h_sync_end    (h_sync_end),
      .v_de_start    (v_de_start),
      .v_de_end      (v_de_end),
      .v_sync_start  (v_sync_start),
      .v_sync_end    (v_sync_end),
      .f2_de_start   (f2_de_start),
      .f2_de_end     (f2_de_end),
      .f2_sync_start (f2_sync_start),
      .f2_sync_end   (f2_sync_end),
      .f2_sync_hpos  (f2_sync_hpos),
      .de_act        (de_act),
      .hs_act        (hs_act),
      .vs_act        (vs_act),
      .x_idx         (x_idx),
      .y_idx         (y_idx)
   );

   rpg_pattern_core #(
      .CH_BITS   (CH_BITS),
      .LINE_LOG2 (LINE_LOG2),
      .IDX_W     (IDX_W)
   ) u_pat (
      .x_idx  (x_idx),
      .y_idx  (y_idx),
      .h_mode (h_mode),
      .v_mode (v_mode),
      .h_rep2 (h_rep2),
      .v_rep2 (v_rep2),
      .h_step (h_step),
      .v_step (v_step),
      .offset (offset),
      .invert (invert),
      .kill   (kill)
   );

   assign de_live = en && de_act;

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      logic [CH_BITS-1:0] seed_k;
      logic [CH_BITS-1:0] sum_k;
      logic [CH_BITS-1:0] gen_k;
      logic [CH_BITS-1:0] act_k;
      logic [CH_BITS-1:0] blank_k;

      assign seed_k = init_color[k*CH_BITS +: CH_BITS];
      assign sum_k  = seed_k + offset;
      assign gen_k  = kill ? '0 : (invert ? ~sum_k : sum_k);

      always_comb begin
         case (chan_sel_e'(ch_sel[2*k +: 2]))
            SEL_ZERO: act_k = '0;
            SEL_MID:  act_k = LVL_MID;
            SEL_FULL: act_k = LVL_FULL;
            default:  act_k = gen_k;
         endcase
      end

      if (k == LUMA_CH) begin : g_luma
         assign blank_k = blank_luma;
      end else begin : g_chroma
         assign blank_k = blank_chroma;
      end

      assign pix_nxt[k*CH_BITS +: CH_BITS] = de_live ? act_k : blank_k;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         de    <= 1'b0;
         hsync <= 1'b0;
         vsync <= 1'b0;
         pix   <= '0;
      end else begin
         de    <= de_live;
         hsync <= (en && hs_act) ? hs_pol : ~hs_pol;
         vsync <= (en && vs_act) ? vs_pol : ~vs_pol;
         pix   <= pix_nxt;
      end
   end

endmodule

// File: rtl/raster_pattern_gen_chk.sv
module raster_pattern_gen_chk #(
   parameter int H_BITS  = 13,
   parameter int CH_BITS = 8,
   parameter int NUM_CH  = 3,
   parameter int LUMA_CH = 1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      en,
   input logic                      hs_pol,
   input logic [H_BITS-1:0]         h_total,
   input logic [H_BITS-1:0]         h_cnt,
   input logic [NUM_CH*2-1:0]       ch_sel,
   input logic [CH_BITS-1:0]        blank_luma,
   input logic                      de,
   input logic                      hsync,
   input logic [NUM_CH*CH_BITS-1:0] pix
);

   logic past_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_valid <= 1'b0;
      else        past_valid <= 1'b1;
   end

   AST_IDLE_NO_DE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !de); // R2

   AST_IDLE_HSYNC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (hsync == !$past(hs_pol))); // R2

   AST_PIXEL_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> ((h_cnt == '0) || (h_cnt == H_BITS'($past(h_cnt) + 1'b1)))); // R3

   AST_PIXEL_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> ((h_cnt == '0) || (h_cnt < $past(h_total)))); // R3

   AST_BLANK_LUMA: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && !de) |-> (pix[LUMA_CH*CH_BITS +: CH_BITS] == $past(blank_luma))); // R13

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ovr
      AST_FORCE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
         (past_valid && de && ($past(ch_sel[2*k +: 2]) == 2'b11)) |->
         (pix[k*CH_BITS +: CH_BITS] == {CH_BITS{1'b1}})); // R12
   end

endmodule

bind raster_pattern_gen raster_pattern_gen_chk #(
   .H_BITS  (H_BITS),
   .CH_BITS (CH_BITS),
   .NUM_CH  (NUM_CH),
   .LUMA_CH (LUMA_CH)
) u_chk (.*);

// File: tb/raster_pattern_gen_bench.sv
`timescale 1ns/1ps
module raster_pattern_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [12:0] h_total, h_de_start, h_de_end, h_sync_start, h_sync_end, f2_sync_hpos;
   logic [11:0] v_total, v_de_start, v_de_end, v_sync_start, v_sync_end;
   logic [11:0] f2_de_start, f2_de_end, f2_sync_start, f2_sync_end;
   logic        interlace_en, hs_pol, vs_pol, h_rep2, v_rep2;
   logic [1:0]  h_mode, v_mode;
   logic [7:0]  h_step, v_step, blank_luma, blank_chroma;
   logic [23:0] init_color;
   logic [5:0]  ch_sel;
   logic [23:0] pix;
   logic        hsync, vsync, de;

   int n_chk = 0;
   int n_fail = 0;
   int mh = 0, mv = 0;
   bit mf = 0;
   int cyc = 0, last_rise = 0;
   bit have_rise = 0, prev_hs_act = 0;

   always #10 clk = ~clk;   // 50 MHz

   raster_pattern_gen u_raster_pattern_gen (.*);

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h (line %0d pixel %0d field %0d)",
                  req, what, act, exp, mv, mh, mf);
      end
   endtask

   function automatic logic [23:0] blank_word();
      return {blank_chroma, blank_luma, blank_chroma};
   endfunction

   task automatic model_out(output bit xde, output bit xhs, output bit xvs,
                            output logic [23:0] xp);
      int vds, vde, vss, vse, hp, x, y, xi, yi, off, val;
      longint p, s, e;
      bit inv, kill;
      if (!en) begin
         xde = 0; xhs = !hs_pol; xvs = !vs_pol; xp = blank_word();
         return;
      end
      vds = mf ? f2_de_start   : v_de_start;
      vde = mf ? f2_de_end     : v_de_end;
      vss = mf ? f2_sync_start : v_sync_start;
      vse = mf ? f2_sync_end   : v_sync_end;
      hp  = mf ? f2_sync_hpos  : 0;
      xde = (mh >= h_de_start) && (mh < h_de_end) && (mv >= vds) && (mv < vde);
      xhs = ((mh >= h_sync_start) && (mh < h_sync_end)) ? hs_pol : !hs_pol;
      p = longint'(mv) * 65536 + mh;
      s = longint'(vss) * 65536 + hp;
      e = longint'(vse) * 65536 + hp;
      xvs = ((p >= s) && (p < e)) ? vs_pol : !vs_pol;
      if (!xde) begin
         xp = blank_word();
         return;
      end
      x = mh - int'(h_de_start);
      y = mv - vds;
      xi = h_rep2 ? x / 2 : x;
      yi = v_rep2 ? y / 2 : y;
      off = 0;
      if (h_mode == 2'b00) off += xi * int'(h_step);
      if (v_mode == 2'b00) off += yi * int'(v_step);
      inv  = ((h_mode == 2'b01) && (xi % 2 == 1)) ^ ((v_mode == 2'b01) && (yi % 2 == 1));
      kill = (h_mode[1] && (xi % 8 != 0)) || (v_mode[1] && (yi % 8 != 0));
      for (int k = 0; k < 3; k++) begin
         val = (int'(init_color[k*8 +: 8]) + off) % 256;
         if (inv)  val = 255 - val;
         if (kill) val = 0;
         case (ch_sel[2*k +: 2])
            2'b01:   val = 0;
            2'b10:   val = 128;
            2'b11:   val = 255;
            default: ;
         endcase
         xp[k*8 +: 8] = 8'(val);
      end
   endtask

   function automatic string pix_req(bit xde);
      if (!en)                       return "R2";
      if (!xde)                      return "R13";
      if (ch_sel != 6'd0)            return "R12";
      if (h_rep2 || v_rep2)          return "R11";
      if (h_mode[1] || v_mode[1])    return "R10";
      if (h_mode == 2'b01 || v_mode == 2'b01) return "R9";
      return "R8";
   endfunction

   task automatic advance();
      if (!en) begin
         mh = 0; mv = 0; mf = 0;
      end else if (mh + 1 >= int'(h_total)) begin
         mh = 0;
         if (mv + 1 >= int'(v_total)) begin
            mv = 0;
            mf = interlace_en ? !mf : 1'b0;
         end else mv++;
      end else mh++;
   endtask

   task automatic step();
      bit xde, xhs, xvs, hs_act_now;
      logic [23:0] xp;
      string rd, rv, rp;
      model_out(xde, xhs, xvs, xp);
      rd = !en ? "R2" : (mf ? "R7" : "R4");
      rv = !en ? "R2" : (mf ? "R7" : "R6");
      rp = pix_req(xde);
      @(posedge clk);
      @(negedge clk);
      cyc++;
      chk(rd, "de", 32'(de), 32'(xde));
      chk(!en ? "R2" : "R5", "hsync", 32'(hsync), 32'(xhs));
      chk(rv, "vsync", 32'(vsync), 32'(xvs));
      chk(rp, "pix", 32'(pix), 32'(xp));
      // R3: hsync active edge repeats every h_total cycles
      hs_act_now = (hsync == hs_pol);
      if (!en) have_rise = 0;
      else if (hs_act_now && !prev_hs_act) begin
         if (have_rise) chk("R3", "hsync period", 32'(cyc - last_rise), 32'(h_total));
         last_rise = cyc;
         have_rise = 1;
      end
      prev_hs_act = hs_act_now;
      advance();
   endtask

   task automatic run(int n);
      repeat (n) step();
   endtask

   task automatic restart();
      en = 1'b0;
      step();
      step();
      en = 1'b1;
   endtask

   task automatic set_base();
      h_total = 24; h_de_start = 4; h_de_end = 20; h_sync_start = 1; h_sync_end = 3;
      v_total = 12; v_de_start = 2; v_de_end = 10; v_sync_start = 0; v_sync_end = 1;
      interlace_en = 0;
      f2_de_start = 3; f2_de_end = 11; f2_sync_start = 0; f2_sync_end = 1; f2_sync_hpos = 12;
      hs_pol = 1; vs_pol = 1;
      h_mode = 2'b00; v_mode = 2'b00; h_rep2 = 0; v_rep2 = 0;
      h_step = 8'd3; v_step = 8'd5;
      init_color = 24'h302010; ch_sel = 6'd0;
      blank_luma = 8'h10; blank_chroma = 8'h80;
   endtask

   task automatic set_random();
      int ht, vt;
      ht = 16 + int'($urandom % 24);
      vt = 8 + int'($urandom % 8);
      h_total = 13'(ht);
      h_de_start = 13'($urandom % 6);
      h_de_end = h_de_start + 13'(4 + $urandom % (ht - int'(h_de_start) - 4));
      h_sync_start = 13'(1 + $urandom % (ht - 3));
      h_sync_end = h_sync_start + 13'(1 + $urandom % (ht - 1 - int'(h_sync_start)));
      v_total = 12'(vt);
      v_de_start = 12'($urandom % 3);
      v_de_end = v_de_start + 12'(2 + $urandom % (vt - int'(v_de_start) - 2));
      v_sync_start = 12'($urandom % 3);
      v_sync_end = v_sync_start + 12'(1 + $urandom % 3);
      f2_de_start = 12'($urandom % 3);
      f2_de_end = f2_de_start + 12'(2 + $urandom % (vt - int'(f2_de_start) - 2));
      f2_sync_start = 12'($urandom % 3);
      f2_sync_end = f2_sync_start + 12'(1 + $urandom % 3);
      f2_sync_hpos = 13'($urandom % ht);
      interlace_en = $urandom % 2;
      hs_pol = $urandom % 2; vs_pol = $urandom % 2;
      h_mode = 2'($urandom); v_mode = 2'($urandom);
      h_rep2 = $urandom % 2; v_rep2 = $urandom % 2;
      h_step = 8'($urandom); v_step = 8'($urandom);
      init_color = 24'($urandom);
      ch_sel = ($urandom % 4 == 0) ? 6'($urandom) : 6'd0;
      blank_luma = 8'($urandom); blank_chroma = 8'($urandom);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd7331));
      set_base();
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "de in reset", 32'(de), 32'd0);
      chk("R1", "hsync in reset", 32'(hsync), 32'd0);
      chk("R1", "vsync in reset", 32'(vsync), 32'd0);
      chk("R1", "pix in reset", 32'(pix), 32'd0);
      rst_n = 1'b1;

      // R8, R4, R5, R6, R3: progressive gradient on both axes
      restart();
      run(2 * 24 * 12);

      // R9: inversion on one axis, then on both
      h_mode = 2'b01; restart(); run(24 * 12);
      v_mode = 2'b01; restart(); run(24 * 12);
      h_mode = 2'b00; restart(); run(24 * 12);

      // R10, R11: line mode with and without the two-step index
      h_de_start = 0; h_de_end = 22; v_de_start = 0; v_de_end = 12;
      h_mode = 2'b10; v_mode = 2'b11; restart(); run(24 * 12);
      h_rep2 = 1; v_rep2 = 1; restart(); run(24 * 12);
      h_mode = 2'b00; v_mode = 2'b00; restart(); run(24 * 12);

      // R12: every override encoding
      set_base();
      ch_sel = {2'b11, 2'b10, 2'b01}; restart(); run(24 * 12);
      ch_sel = {2'b00, 2'b11, 2'b00}; restart(); run(24 * 12);

      // R7: interlaced fields with a mid-line vsync in field 1
      set_base();
      interlace_en = 1; f2_sync_start = 1; f2_sync_end = 3;
      restart(); run(3 * 24 * 12);

      // R5, R6: active-low syncs
      set_base();
      hs_pol = 0; vs_pol = 0; restart(); run(24 * 12);

      // R2: disable in the middle of a frame, then resume from the origin
      set_base();
      restart(); run(100);
      en = 1'b0; run(3);
      en = 1'b1; run(300);

      // random configurations
      for (int i = 0; i < 10; i++) begin
         set_random();
         restart();
         run(2 * int'(h_total) * int'(v_total) + 5);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule